// File: doc/BRIEF.md
# Tuner Synthesizer Control Receiver

This block receives write telegrams from a host over a two-wire serial bus and turns them into the static settings of a frequency-synthesizer tuner: a 15-bit feedback divider word, four loop and test control bits, and five general-purpose port bits. It only receives. The only thing it ever drives onto the bus is the acknowledge, through an open-drain pull-down request.

A telegram opens with a start condition and an address byte. The upper five bits of that byte are fixed. The next two bits must equal the strapped chip-select input, and the lowest bit must be 0, meaning a write. After the address, data arrives in pairs of bytes. The top bit of the first byte of a pair chooses the type of the pair: 0 means a divider pair and 1 means a control pair. A telegram may hold pairs of both types in either order, and it may end with a stop after any byte.

SCL and SDA are brought into the system clock domain through two-flop synchronisers. All bus events are derived from the synchronised levels.

Top module: `tuner_i2c_regs`

## Requirements
- R1: After power-on reset the divider word, the four control bits and the five port bits are all 0, and `sda_pull_o` is 0.
- R2: An address byte is acknowledged only when it equals binary 1100_0, then `chip_sel[1]`, then `chip_sel[0]`, then 0 (MSB first). A value of 1 in the last bit is never acknowledged.
- R3: After an address that does not match, neither that byte nor any later byte is acknowledged, and no register changes until the next start.
- R4: A pair whose first byte has MSB 0 is a divider pair. Bits 6:0 of the first byte load `divider_o[14:8]`, and the second byte loads `divider_o[7:0]`.
- R5: A pair whose first byte has MSB 1 is a control pair. In the first byte, bit 6 drives `pump_hi_o`, bit 5 drives `tmode_sig_o`, bit 4 drives `tmode_tri_o` and bit 0 drives `amp_off_o`; bits 3:1 are ignored. In the second byte, bit 7 drives `port_o[4]`, bit 4 drives `port_o[3]` and bits 2:0 drive `port_o[2:0]`; the other bits are ignored.
- R6: Every accepted byte is acknowledged. `sda_pull_o` rises at the SCL fall that follows the eighth data bit and falls at the SCL fall that follows the ninth clock. It never changes while the synchronised SCL is high, and it is 0 at all other times.
- R7: A single telegram may carry a divider pair and a control pair in either order.
- R8: The first byte of a pair takes effect as soon as it is received, and the second byte takes effect when its acknowledge starts. A telegram that ends after the first byte leaves the fields of the second byte unchanged.
- R9: The type of a pair is decided by its first byte alone. The MSB of the second byte is ordinary data.
- R10: A start that arrives in the middle of a byte discards the partial byte and begins a new address byte.
- R11: After a stop, SCL pulses without a new start produce no acknowledge and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| por_n | input | 1 | Power-on reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| chip_sel | input | 2 | Strapped address bits compared with address bits 2:1 |
| sda_pull_o | output | 1 | 1 requests the open-drain SDA pull-down (acknowledge) |
| divider_o | output | 15 | Synthesizer divider word |
| pump_hi_o | output | 1 | Charge-pump high-current select |
| tmode_sig_o | output | 1 | Test bit routing the divided signal to a port |
| tmode_tri_o | output | 1 | Test bit placing the pump output in high impedance |
| amp_off_o | output | 1 | Tuning amplifier disable |
| port_o | output | 5 | Port bits {P7, P4, P2, P1, P0} |

## Verification
The properties assume that the bus obeys the two-wire protocol. SDA moves only while SCL is low, except for start and stop. The host never issues a start or stop while the block holds SDA low. Each SCL phase lasts longer than the synchroniser delay.

The bench's bus tasks respect these rules by construction. Every SCL quarter-phase lasts ten system clocks. SDA is changed only in the low phase. Starts and stops are issued only after the acknowledge has been released. SDA is modelled as a wired-AND of the host drive and the block's pull-down request.

// File: rtl/tuner_i2c_regs.sv
module tuner_i2c_regs #(
  parameter int DIV_W = 15
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [1:0]       chip_sel,
  output logic             sda_pull_o,
  output logic [DIV_W-1:0] divider_o,
  output logic             pump_hi_o,
  output logic             tmode_sig_o,
  output logic             tmode_tri_o,
  output logic             amp_off_o,
  output logic [4:0]       port_o
);

  localparam int HI_W = DIV_W - 8;

  typedef enum logic [2:0] {S_IDLE, S_RECV, S_ACKW, S_ACK, S_SKIP} st_t;

  st_t        st;
  logic [1:0] scl_m, sda_m;
  logic       scl_s, sda_s, scl_q, sda_q;
  logic [7:0] shreg;
  logic [2:0] cnt;
  logic       is_addr, pend, pend_ctl, second;
  logic       sda_pull;
  logic [DIV_W-1:0] div_q;
  logic [3:0] ctl_q;
  logic [4:0] port_q;

  assign scl_s = scl_m[1];
  assign sda_s = sda_m[1];

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire [7:0] byte_nx  = {shreg[6:0], sda_s};
  wire [7:0] own_addr = {5'b11000, chip_sel, 1'b0};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      scl_m    <= 2'b11;
      sda_m    <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      st       <= S_IDLE;
      shreg    <= '0;
      cnt      <= '0;
      is_addr  <= 1'b0;
      pend     <= 1'b0;
      pend_ctl <= 1'b0;
      second   <= 1'b0;
      sda_pull <= 1'b0;
      div_q    <= '0;
      ctl_q    <= '0;
      port_q   <= '0;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
      if (start_c) begin
        st       <= S_RECV;
        is_addr  <= 1'b1;
        cnt      <= '0;
        pend     <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_c) begin
        st       <= S_IDLE;
        pend     <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        case (st)
          S_RECV: if (scl_rise) begin
            shreg <= byte_nx;
            cnt   <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              if (is_addr) begin
                is_addr <= 1'b0;
                second  <= 1'b0;
                st      <= (byte_nx == own_addr) ? S_ACKW : S_SKIP;
              end else begin
                st <= S_ACKW;
                if (!pend) begin
                  pend     <= 1'b1;
                  pend_ctl <= byte_nx[7];
                  second   <= 1'b0;
                  if (byte_nx[7])
                    ctl_q <= {byte_nx[6], byte_nx[5], byte_nx[4], byte_nx[0]};
                  else
                    div_q[DIV_W-1:8] <= byte_nx[HI_W-1:0];
                end else begin
                  pend   <= 1'b0;
                  second <= 1'b1;
                end
              end
            end
          end
          S_ACKW: if (scl_fall) begin
            sda_pull <= 1'b1;
            st       <= S_ACK;
            if (second) begin
              if (pend_ctl)
                port_q <= {shreg[7], shreg[4], shreg[2:0]};
              else
                div_q[7:0] <= shreg;
            end
          end
          S_ACK: if (scl_fall) begin
            sda_pull <= 1'b0;
            cnt      <= '0;
            st       <= S_RECV;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o  = sda_pull;
  assign divider_o   = div_q;
  assign pump_hi_o   = ctl_q[3];
  assign tmode_sig_o = ctl_q[2];
  assign tmode_tri_o = ctl_q[1];
  assign amp_off_o   = ctl_q[0];
  assign port_o      = port_q;

  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(sda_pull) |-> !scl_s); // R6
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_SKIP) |-> !sda_pull); // R3
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!por_n)
    (st == S_IDLE) |-> !sda_pull); // R11
  AST_DIV_ON_RX: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(div_q) |-> ($past(st) == S_RECV || $past(st) == S_ACKW)); // R4
  AST_PORT_ON_ACK: assert property (@(posedge clk) disable iff (!por_n)
    !$stable(port_q) |-> ($past(st) == S_ACKW && $rose(sda_pull))); // R8
  AST_START_RESTART: assert property (@(posedge clk) disable iff (!por_n)
    start_c |=> (st == S_RECV && is_addr && cnt == 3'd0)); // R10

endmodule

// File: tb/tuner_i2c_regs_test.sv
module tuner_i2c_regs_test;
  localparam int QTR = 10;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [1:0]  chip_sel = 2'd0;
  logic        sda_pull_o;
  logic [14:0] divider_o;
  logic        pump_hi_o, tmode_sig_o, tmode_tri_o, amp_off_o;
  logic [4:0]  port_o;
  wire         sda_line = sda_m & ~sda_pull_o;

  int applied = 0;
  int miscomp = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tuner_i2c_regs uut (
    .clk(clk), .por_n(por_n), .scl_i(scl_m), .sda_i(sda_line),
    .chip_sel(chip_sel), .sda_pull_o(sda_pull_o), .divider_o(divider_o),
    .pump_hi_o(pump_hi_o), .tmode_sig_o(tmode_sig_o), .tmode_tri_o(tmode_tri_o),
    .amp_off_o(amp_off_o), .port_o(port_o)
  );

  // {cs[1:0], nbytes[2:0], bytes[39:0] first byte high, div[14:0], ctl{pump,sig,tri,amp}, port[4:0], ack[4:0]}
  localparam logic [73:0] VEC [0:7] = '{
    {2'd0, 3'd3, 40'hC012340000, 15'h1234, 4'h0, 5'b00000, 5'b11100}, // R4 divider pair
    {2'd1, 3'd5, 40'hC27FFFC385, 15'h7FFF, 4'h9, 5'b10101, 5'b11111}, // R7 divider then control, R5
    {2'd2, 3'd3, 40'hC005000000, 15'h7FFF, 4'h9, 5'b10101, 5'b00000}, // R3 wrong chip select
    {2'd2, 3'd2, 40'hC401000000, 15'h01FF, 4'h9, 5'b10101, 5'b11000}, // R8 ends after first divider byte
    {2'd3, 3'd4, 40'hC6B2120000, 15'h00FF, 4'h6, 5'b01010, 5'b11110}, // R7 control then divider, R8
    {2'd0, 3'd3, 40'hC005A50000, 15'h05A5, 4'h6, 5'b01010, 5'b11100}, // R9 second byte MSB 1
    {2'd0, 3'd3, 40'hC110000000, 15'h05A5, 4'h6, 5'b01010, 5'b00000}, // R2 read bit set
    {2'd0, 3'd2, 40'hC080000000, 15'h05A5, 4'h0, 5'b01010, 5'b11000}  // R8 ends after first control byte
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qwait();
    scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qwait();
      scl_m = 1'b1; qwait();
      if (i == 7) chk("R6 released during data", {31'd0, sda_pull_o}, 32'd0);
      qwait();
      scl_m = 1'b0; qwait();
    end
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    ack = sda_pull_o;
    qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic chk_regs(input string req, input logic [14:0] d, input logic [3:0] c, input logic [4:0] p);
    chk({req, " divider"}, {17'd0, divider_o}, {17'd0, d});
    chk({req, " control"}, {28'd0, pump_hi_o, tmode_sig_o, tmode_tri_o, amp_off_o}, {28'd0, c});
    chk({req, " ports"}, {27'd0, port_o}, {27'd0, p});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscomp++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
      $finish;
    end
  end

  initial begin
    logic a;
    repeat (5) @(negedge clk);
    chk_regs("R1 reset", 15'h0, 4'h0, 5'h0);
    chk("R1 reset pull", {31'd0, sda_pull_o}, 32'd0);
    por_n = 1'b1;
    repeat (20) @(negedge clk);
    chk_regs("R1 after release", 15'h0, 4'h0, 5'h0);

    for (int v = 0; v < 8; v++) begin
      logic [73:0] e;
      e = VEC[v];
      chip_sel = e[73:72];
      bus_start();
      for (int k = 0; k < int'(e[71:69]); k++) begin
        send_byte(e[68-8*k -: 8], a);
        chk($sformatf("R2/R3 ack vec %0d byte %0d", v, k), {31'd0, a}, {31'd0, e[4-k]});
      end
      bus_stop();
      repeat (20) @(negedge clk);
      chk_regs($sformatf("R4/R5 vec %0d", v), e[28:14], e[13:10], e[9:5]);
    end

    // R10: start in the middle of a divider byte
    chip_sel = 2'd0;
    bus_start();
    send_byte(8'hC0, a);
    chk("R10 first address ack", {31'd0, a}, 32'd1);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_byte(8'hC0, a);
    chk("R10 restarted address ack", {31'd0, a}, 32'd1);
    send_byte(8'h03, a);
    send_byte(8'h33, a);
    bus_stop();
    repeat (20) @(negedge clk);
    chk_regs("R10", 15'h0333, 4'h0, 5'b01010);

    // R11: clocking after a stop without a start
    scl_m = 1'b0; qwait();
    send_byte(8'hC0, a);
    chk("R11 no ack without start", {31'd0, a}, 32'd0);
    send_byte(8'h11, a);
    chk("R11 no ack data", {31'd0, a}, 32'd0);
    repeat (20) @(negedge clk);
    chk_regs("R11", 15'h0333, 4'h0, 5'b01010);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
    $finish;
  end
endmodule